// File: doc/BRIEF.md
# Register Readiness Scoreboard with Operand Wakeup

This block keeps one ready bit for each physical register of an out-of-order core. It also keeps, for each slot of a small waiting queue, a record of which source operands are still outstanding. A dispatching instruction is written into a chosen slot with up to two source tags and one destination tag. A completing producer broadcasts its destination tag. The broadcast sets the register's ready bit and clears the matching pending operand in every live slot.

Each slot drives a ready line. The line is high when the slot holds a live, unsquashed instruction whose sources are all available. The issue logic picks from these lines and later frees the slot with a release mask. A squash mask kills slots during a pipeline flush. Tags at or above the physical register count are treated as untracked, so they never block a slot and never alter the scoreboard.

Top module: `regrdy_wakeup`

## Requirements
- R1: While reset is held, and in the first cycle after it, every bit of `reg_ready` and `slot_ready` is 0.
- R2: A dispatch with `disp_dst_vld`=1 and an in-range destination tag makes `reg_ready[tag]` read 0 in the cycle after the dispatch edge.
- R3: A completion of in-range tag T makes `reg_ready[T]` read 1 after the edge. Every live slot whose pending operand carries T treats that operand as available from the same point.
- R4: A tag at or above `NUM_PREGS` is untracked. As a source it never holds a slot back. As a completion or as a destination it leaves `reg_ready` unchanged.
- R5: A source operand with its valid bit at 0, or with its rename-ready flag at 1, never holds a slot back.
- R6: A source that is not flagged ready, but whose `reg_ready` bit already reads 1 at dispatch, is taken as available straight away.
- R7: If a completion of tag T and a dispatch that reads T as a source share a cycle, the dispatched operand is captured as available.
- R8: If a completion of T and a dispatch naming T as destination share a cycle, `reg_ready[T]` reads 0 afterwards, because the new producer wins.
- R9: A squashed slot holds `slot_ready` at 0 and drops its pending operands, so a later completion of a tag it was waiting on does not raise its ready line.
- R10: `slot_ready[i]` is 1 only when slot i is valid, not squashed and has no pending source. A release clears the slot, and a dispatch into a slot takes priority over a release or squash of that slot in the same cycle.
- R11: A completion clears only operands whose tag matches. A slot with two pending sources stays not ready until both tags have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_slot | input | SLOT_W | Target queue slot for the dispatch |
| disp_dst_vld | input | 1 | Dispatch names a destination |
| disp_dst | input | TAG_W | Destination register tag |
| disp_src_vld | input | 2 | Per-source valid (bit k is source k) |
| disp_src_rdy | input | 2 | Per-source rename-ready flag |
| disp_src_tag | input | 2 x TAG_W | Source register tags, index k is source k |
| cmpl_valid | input | 1 | Completion broadcast strobe |
| cmpl_tag | input | TAG_W | Tag of the completing producer |
| squash_mask | input | NUM_SLOTS | Per-slot squash request |
| release_mask | input | NUM_SLOTS | Per-slot free request |
| slot_ready | output | NUM_SLOTS | Per-slot all-operands-available line |
| reg_ready | output | NUM_PREGS | Scoreboard ready bits |

## Verification
The bench sweeps every tag value of a 5-bit tag space against 16 physical registers. The sweep applies completions, destination writes and source dispatches, and checks that the range boundary sits exactly at 16. An off-by-one in that compare would either track tag 16 or leave register 15 stuck.

Two same-cycle races get their own directed checks. In the first, a dispatch reads a tag in the cycle that tag completes. A design without the bypass would leave that slot waiting forever. In the second, a completion and a new destination name the same tag. A wrong priority would leave the register falsely ready.

The squash test completes the tag a killed slot was waiting on. A design that kept pending state alive would then raise a ready line for a dead instruction. A further check confirms that a two-source slot ignores a completion that matches only one of its operands.

// File: rtl/regrdy_pkg.sv
package regrdy_pkg;

    localparam int SRC_CNT = 2;

    typedef logic [SRC_CNT-1:0] src_mask_t;

    // Tags at or beyond the limit are untracked
    function automatic logic tag_tracked(input int unsigned tag, input int unsigned lim);
        return tag < lim;
    endfunction

endpackage

// File: rtl/regrdy_scoreboard.sv
module regrdy_scoreboard
    import regrdy_pkg::*;
#(
    parameter int NUM_PREGS = 16,
    parameter int TAG_W     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              set_vld_i,
    input  logic [TAG_W-1:0]                  set_tag_i,
    input  logic                              clr_vld_i,
    input  logic [TAG_W-1:0]                  clr_tag_i,
    input  logic [SRC_CNT-1:0][TAG_W-1:0]     look_tag_i,
    output src_mask_t                         look_rdy_o,
    output logic [NUM_PREGS-1:0]              rdy_o
);

    localparam int IDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;

    typedef struct packed {
        logic [NUM_PREGS-1:0] rdy;
    } sb_t;

    sb_t sb_d, sb_q;

    logic set_hit, clr_hit;
    assign set_hit = set_vld_i && tag_tracked(32'(set_tag_i), NUM_PREGS);
    assign clr_hit = clr_vld_i && tag_tracked(32'(clr_tag_i), NUM_PREGS);

    always_comb begin
        sb_d = sb_q;
        if (set_hit) sb_d.rdy[set_tag_i[IDX_W-1:0]] = 1'b1;
        // a newly dispatched producer overrides a same-cycle completion
        if (clr_hit) sb_d.rdy[clr_tag_i[IDX_W-1:0]] = 1'b0;
    end

    always_comb begin
        for (int k = 0; k < SRC_CNT; k++) begin
            if (!tag_tracked(32'(look_tag_i[k]), NUM_PREGS))
                look_rdy_o[k] = 1'b1;
            else
                look_rdy_o[k] = sb_q.rdy[look_tag_i[k][IDX_W-1:0]] ||
                                (set_hit && set_tag_i == look_tag_i[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign rdy_o = sb_q.rdy;

    a_r2_dst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !sb_q.rdy[$past(clr_tag_i[IDX_W-1:0])]);

    a_r3_cmpl_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !(clr_vld_i && clr_tag_i == set_tag_i)) |=> sb_q.rdy[$past(set_tag_i[IDX_W-1:0])]);

    a_r4_untracked_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld_i && !tag_tracked(32'(set_tag_i), NUM_PREGS) && !clr_hit) |=> $stable(sb_q.rdy));

endmodule

// File: rtl/regrdy_slot.sv
module regrdy_slot
    import regrdy_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_i,
    input  logic [SRC_CNT-1:0][TAG_W-1:0] src_tag_i,
    input  src_mask_t                     src_pend_i,
    input  logic                          wake_i,
    input  logic [TAG_W-1:0]              wake_tag_i,
    input  logic                          squash_i,
    input  logic                          release_i,
    output logic                          ready_o
);

    typedef struct packed {
        logic                          valid;
        logic                          squashed;
        src_mask_t                     pend;
        logic [SRC_CNT-1:0][TAG_W-1:0] tag;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (disp_i) begin
            s_d.valid    = 1'b1;
            s_d.squashed = 1'b0;
            s_d.pend     = src_pend_i;
            s_d.tag      = src_tag_i;
        end else if (release_i) begin
            s_d.valid    = 1'b0;
            s_d.squashed = 1'b0;
            s_d.pend     = '0;
        end else if (squash_i && s_q.valid) begin
            s_d.squashed = 1'b1;
            s_d.pend     = '0;
        end else if (wake_i && s_q.valid && !s_q.squashed) begin
            for (int k = 0; k < SRC_CNT; k++)
                if (s_q.tag[k] == wake_tag_i) s_d.pend[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready_o = s_q.valid && !s_q.squashed && (s_q.pend == '0);

    a_r9_squash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_i && !disp_i && !release_i) |=> !ready_o);

    a_r10_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !disp_i) |=> !ready_o);

endmodule

// File: rtl/regrdy_wakeup.sv
module regrdy_wakeup
    import regrdy_pkg::*;
#(
    parameter  int NUM_PREGS = 16,
    parameter  int NUM_SLOTS = 4,
    parameter  int TAG_W     = 5,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              disp_valid,
    input  logic [SLOT_W-1:0]                 disp_slot,
    input  logic                              disp_dst_vld,
    input  logic [TAG_W-1:0]                  disp_dst,
    input  logic [1:0]                        disp_src_vld,
    input  logic [1:0]                        disp_src_rdy,
    input  logic [1:0][TAG_W-1:0]             disp_src_tag,
    input  logic                              cmpl_valid,
    input  logic [TAG_W-1:0]                  cmpl_tag,
    input  logic [NUM_SLOTS-1:0]              squash_mask,
    input  logic [NUM_SLOTS-1:0]              release_mask,
    output logic [NUM_SLOTS-1:0]              slot_ready,
    output logic [NUM_PREGS-1:0]              reg_ready
);

    src_mask_t look_rdy;
    src_mask_t src_pend;
    logic      wake_vld;

    regrdy_scoreboard #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vld_i  (cmpl_valid),
        .set_tag_i  (cmpl_tag),
        .clr_vld_i  (disp_valid && disp_dst_vld),
        .clr_tag_i  (disp_dst),
        .look_tag_i (disp_src_tag),
        .look_rdy_o (look_rdy),
        .rdy_o      (reg_ready)
    );

    // an operand waits only if present, not flagged by rename and not yet produced
    assign src_pend = disp_src_vld & ~disp_src_rdy & ~look_rdy;
    assign wake_vld = cmpl_valid && tag_tracked(32'(cmpl_tag), NUM_PREGS);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        regrdy_slot #(.TAG_W(TAG_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .disp_i     (disp_valid && disp_slot == SLOT_W'(g)),
            .src_tag_i  (disp_src_tag),
            .src_pend_i (src_pend),
            .wake_i     (wake_vld),
            .wake_tag_i (cmpl_tag),
            .squash_i   (squash_mask[g]),
            .release_i  (release_mask[g]),
            .ready_o    (slot_ready[g])
        );
    end

    a_r7_same_cycle_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_src_vld == 2'b01 && cmpl_valid &&
         tag_tracked(32'(cmpl_tag), NUM_PREGS) && disp_src_tag[0] == cmpl_tag)
        |=> slot_ready[$past(disp_slot)]);

    a_r5_no_sources_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_src_vld == 2'b00) |=> slot_ready[$past(disp_slot)]);

endmodule

// File: tb/sim_regrdy_wakeup.sv
module sim_regrdy_wakeup;

    localparam int NP = 16;
    localparam int NS = 4;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_valid;
    logic [1:0]    disp_slot;
    logic          disp_dst_vld;
    logic [TW-1:0] disp_dst;
    logic [1:0]    disp_src_vld;
    logic [1:0]    disp_src_rdy;
    logic [1:0][TW-1:0] disp_src_tag;
    logic          cmpl_valid;
    logic [TW-1:0] cmpl_tag;
    logic [NS-1:0] squash_mask;
    logic [NS-1:0] release_mask;
    logic [NS-1:0] slot_ready;
    logic [NP-1:0] reg_ready;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [NP-1:0] exp_sb;

    always #10 clk = ~clk;

    regrdy_wakeup #(.NUM_PREGS(NP), .NUM_SLOTS(NS), .TAG_W(TW)) u0 (.*);

    task automatic idle();
        disp_valid = 0; disp_slot = 0; disp_dst_vld = 0; disp_dst = 0;
        disp_src_vld = 0; disp_src_rdy = 0; disp_src_tag = '0;
        cmpl_valid = 0; cmpl_tag = 0; squash_mask = 0; release_mask = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply current inputs across one rising edge, then return them to idle
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic complete(input int t);
        cmpl_valid = 1; cmpl_tag = TW'(t);
        step();
        if (t < NP) exp_sb[t] = 1'b1;
    endtask

    task automatic dispatch(input int slot, input int ta, input bit va, input bit ra,
                            input int tb, input bit vb, input bit rb);
        disp_valid = 1; disp_slot = 2'(slot);
        disp_src_tag[0] = TW'(ta); disp_src_vld[0] = va; disp_src_rdy[0] = ra;
        disp_src_tag[1] = TW'(tb); disp_src_vld[1] = vb; disp_src_rdy[1] = rb;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        exp_sb = '0;
        repeat (3) @(negedge clk);
        chk("R1 reg_ready in reset", 32'(reg_ready), 0);
        chk("R1 slot_ready in reset", 32'(slot_ready), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reg_ready after reset", 32'(reg_ready), 0);
        chk("R1 slot_ready after reset", 32'(slot_ready), 0);

        // R3 / R4: completion sweep over every tag
        for (int t = 0; t < 32; t++) begin
            complete(t);
            chk("R3,R4 completion sweep", 32'(reg_ready), 32'(exp_sb));
        end
        chk("R3 all tracked set", 32'(reg_ready), 32'hFFFF);

        // R2 / R4 / R5: destination sweep, dispatches carry no sources
        for (int t = 0; t < 32; t++) begin
            dispatch(t % NS, 0, 0, 0, 0, 0, 0);
            disp_dst_vld = 1; disp_dst = TW'(t);
            step();
            if (t < NP) exp_sb[t] = 1'b0;
            chk("R2,R4 destination sweep", 32'(reg_ready), 32'(exp_sb));
            chk("R5 sourceless slot ready", 32'(slot_ready[t % NS]), 1);
        end
        release_mask = '1;
        step();
        chk("R10 release clears", 32'(slot_ready), 0);

        // R4 / R5 / R6: source sweep against an all-clear scoreboard
        for (int t = 0; t < 32; t++) begin
            for (int f = 0; f < 2; f++) begin
                dispatch(0, t, 1, f[0], 0, 0, 0);
                step();
                chk("R4,R5 source sweep", 32'(slot_ready[0]), 32'((f == 1) || (t >= NP)));
            end
        end
        release_mask = '1;
        step();

        // R6: scoreboard already ready at dispatch
        complete(3);
        dispatch(1, 3, 1, 0, 4, 1, 1);
        step();
        chk("R6 scoreboard hit at dispatch", 32'(slot_ready), 32'b0010);
        release_mask = '1;
        step();

        // R3 / R11: selective wakeup
        dispatch(1, 5, 1, 0, 6, 1, 0); step();
        dispatch(2, 5, 1, 0, 0, 0, 0); step();
        dispatch(3, 7, 1, 0, 0, 0, 0); step();
        chk("R3 all waiting", 32'(slot_ready), 0);
        complete(5);
        chk("R3 wake tag 5", 32'(slot_ready), 32'b0100);
        chk("R11 partial match keeps slot", 32'(slot_ready[1]), 0);
        complete(6);
        chk("R11 second tag completes slot", 32'(slot_ready), 32'b0110);
        complete(7);
        chk("R3 wake tag 7", 32'(slot_ready), 32'b1110);
        chk("R3 scoreboard bits", 32'(reg_ready), 32'(exp_sb));
        release_mask = '1;
        step();

        // R7: dispatch reads the tag completing in the same cycle
        dispatch(0, 9, 1, 0, 0, 0, 0);
        cmpl_valid = 1; cmpl_tag = 9;
        step();
        exp_sb[9] = 1'b1;
        chk("R7 same-cycle capture", 32'(slot_ready[0]), 1);
        chk("R7 scoreboard", 32'(reg_ready), 32'(exp_sb));

        // R8: completion and new producer of same tag
        dispatch(1, 0, 0, 0, 0, 0, 0);
        disp_dst_vld = 1; disp_dst = 10;
        cmpl_valid = 1; cmpl_tag = 10;
        step();
        chk("R8 new producer wins", 32'(reg_ready[10]), 0);
        release_mask = '1;
        step();

        // R9: squashed slot ignores later wakeup
        dispatch(3, 11, 1, 0, 0, 0, 0); step();
        squash_mask = 4'b1000; step();
        chk("R9 squashed not ready", 32'(slot_ready), 0);
        complete(11);
        chk("R9 wakeup after squash", 32'(slot_ready), 0);
        chk("R3 reg 11 set", 32'(reg_ready[11]), 1);
        dispatch(2, 0, 0, 0, 0, 0, 0); step();
        chk("R10 ready slot", 32'(slot_ready), 32'b0100);
        squash_mask = 4'b0100; step();
        chk("R9 squash ready slot", 32'(slot_ready), 0);

        // R10: dispatch wins over same-cycle release
        dispatch(0, 0, 0, 0, 0, 0, 0);
        release_mask = 4'b0001;
        step();
        chk("R10 dispatch beats release", 32'(slot_ready[0]), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule